// File: doc/BRIEF.md
# Dual-Channel High/Low Count PWM

This peripheral drives two independent pulse-width outputs, A and B. Software describes each waveform by two lengths, a high-phase count and a low-phase count, instead of a period and a compare value. Every period begins with the high phase and then runs the low phase. Each length is measured in channel ticks. A channel tick is made by picking one of four shared source tick enables and dividing it by a 7-bit prescaler plus one.

A small synchronous register bus holds three words: one count word per channel and one shared control word. The control word carries, for each channel, the source select, the prescaler, a gate for the prescaler and an output enable. The block has no polarity hardware. To invert a waveform, software swaps the two counts.

Count updates made while a channel runs are held until the next period boundary. Setting an output enable restarts its channel at the start of the high phase. Clearing it forces the output low on the next clock edge.

Top module: `dual_hl_pwm`

## Requirements
- R1: After reset both outputs are 0 and all three registers read as zero.
- R2: Word addresses decode as follows: 0x0 is the channel A count word, 0x4 is the channel B count word and 0x8 is the control word. Control bits 3:2 and 31:24 always read 0. Any other address reads 0, and writes to it change nothing.
- R3: Control word fields: output enable A at bit 0 and B at bit 1; source select A at bits 5:4 and B at bits 7:6; prescaler A at bits 14:8 and B at bits 22:16; prescaler gate A at bit 15 and B at bit 23. A channel tick happens on every (prescaler+1)-th cycle in which `src_tick[select]` is 1.
- R4: While a channel's gate bit is 0, its prescaler does not advance, and its output holds its value unless the bus writes.
- R5: In a count word, bits 31:16 give the high-phase length and bits 15:0 give the low-phase length, both in channel ticks. The output is high for the high length, then low for the low length, and then the period repeats.
- R6: A control write that clears a channel's enable drives that output to 0 from the same clock edge, whatever point of the period it is at.
- R7: A high length of 0 keeps the output low. A low length of 0 with a nonzero high length keeps it high. Both lengths at 0 keep it low.
- R8: A count word written while its channel runs takes effect at the next period boundary. A write that lands in the boundary cycle itself first applies at the boundary after that.
- R9: A control write that sets an enable which was clear restarts that channel. Its prescaler clears, the current count word is loaded, and the output is high from that edge when the high length is nonzero.
- R10: The two channels run independently of each other. Writes to one channel's count word do not disturb the other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 4 | Source tick enables, one per selectable source |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pwm_out | output | 2 | Output bit 0 is channel A, bit 1 is channel B |

## Verification
Two events can fall in the same cycle. A count word write can coincide with the final tick of a period. An enable-setting control write can coincide with a prescaler terminal tick. The bench sweeps the write cycle across every offset of a short period, so that some writes land exactly on the boundary and some land on a terminal tick. A behavioural model of remaining ticks per phase decides the expected output on every clock. In that model, a write in the boundary cycle is seen only at the boundary after it, and a restart overrides the tick of its own cycle.

// File: rtl/dual_hl_pwm.sv
module dual_hl_pwm #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        src_tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [1:0]        pwm_out
);

  localparam logic [ADDR_W-1:0] OFS_A    = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_B    = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(8);
  localparam logic [31:0]       CTRL_MASK = 32'h00FF_FFF3;

  logic [31:0] cnt_q [2];
  logic [31:0] ctrl_q;

  wire wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_MASK;

  always_comb begin
    case (bus_addr)
      OFS_A:    bus_rdata = cnt_q[0];
      OFS_B:    bus_rdata = cnt_q[1];
      OFS_CTRL: bus_rdata = ctrl_q;
      default:  bus_rdata = '0;
    endcase
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    localparam int EN_BIT = ch;
    localparam int SEL_LO = 4 + 2*ch;
    localparam int DIV_LO = 8 + 8*ch;
    localparam int CE_BIT = 15 + 8*ch;
    localparam logic [ADDR_W-1:0] OFS = (ch == 0) ? OFS_A : OFS_B;

    logic [6:0]  pc;
    logic [15:0] run_hi, run_lo, pos;
    logic        hi_ph;

    wire [1:0]  sel    = ctrl_q[SEL_LO +: 2];
    wire [6:0]  div    = ctrl_q[DIV_LO +: 7];
    wire        ce     = ctrl_q[CE_BIT];
    wire        en     = ctrl_q[EN_BIT];
    wire        start  = wr_ctrl && bus_wdata[EN_BIT] && !en;
    wire        adv    = ce && src_tick[sel];
    wire        tick   = adv && (pc == div);
    wire [15:0] new_hi = cnt_q[ch][31:16];
    wire [15:0] new_lo = cnt_q[ch][15:0];
    wire [16:0] pos_nx = {1'b0, pos} + 17'd1;
    wire        ph_end = pos_nx >= {1'b0, (hi_ph ? run_hi : run_lo)};

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                          cnt_q[ch] <= '0;
      else if (bus_wr && bus_addr == OFS) cnt_q[ch] <= bus_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pc     <= '0;
        run_hi <= '0;
        run_lo <= '0;
        pos    <= '0;
        hi_ph  <= 1'b0;
      end else if (start) begin
        pc     <= '0;
        run_hi <= new_hi;
        run_lo <= new_lo;
        pos    <= '0;
        hi_ph  <= (new_hi != 16'd0);
      end else begin
        if (adv) pc <= tick ? 7'd0 : pc + 7'd1;
        if (en && tick) begin
          if (!ph_end) begin
            pos <= pos_nx[15:0];
          end else begin
            pos <= '0;
            if (hi_ph && run_lo != 16'd0) begin
              hi_ph <= 1'b0;
            end else begin
              run_hi <= new_hi;
              run_lo <= new_lo;
              hi_ph  <= (new_hi != 16'd0);
            end
          end
        end
      end
    end

    assign pwm_out[ch] = en && hi_ph;
  end

endmodule

module dual_hl_pwm_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [1:0]        pwm_out,
  input logic [31:0]       ctrl_q
);
  localparam logic [ADDR_W-1:0] CTRL_AT = ADDR_W'(8);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> pwm_out == 2'b00);

  // R6
  a_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == CTRL_AT && !bus_wdata[0]) |=> !pwm_out[0]);

  // R6
  b_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == CTRL_AT && !bus_wdata[1]) |=> !pwm_out[1]);

  // R2
  ctrl_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == CTRL_AT) |-> (bus_rdata[3:2] == 2'b00 && bus_rdata[31:24] == 8'h00));

  // R4
  a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[15] && !bus_wr) |=> $stable(pwm_out[0]));

  // R4
  b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[23] && !bus_wr) |=> $stable(pwm_out[1]));
endmodule

bind dual_hl_pwm dual_hl_pwm_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out), .ctrl_q(ctrl_q)
);

// File: tb/dual_hl_pwm_tb.sv
module dual_hl_pwm_tb;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src_tick = '0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  pwm_out;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0, model_on = 0;

  int m_cnt[2], m_pc[2], m_left[2], m_hi[2], m_lo[2];
  bit m_high[2];
  int m_ctrl;

  dual_hl_pwm u_dut (.*);

  always #(CLK_NS/2) clk = ~clk;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    src_tick[0] <= 1'b1;
    src_tick[1] <= (cyc % 2) == 0;
    src_tick[2] <= (cyc % 3) == 0;
    src_tick[3] <= 1'($urandom);
  end

  function automatic bit f_en(int ch);   return ((m_ctrl >> ch) & 1) != 0;        endfunction
  function automatic int f_sel(int ch);  return (m_ctrl >> (4 + 2*ch)) & 3;       endfunction
  function automatic int f_div(int ch);  return (m_ctrl >> (8 + 8*ch)) & 127;     endfunction
  function automatic bit f_ce(int ch);   return ((m_ctrl >> (15 + 8*ch)) & 1) != 0; endfunction

  function automatic void load(int ch);
    m_hi[ch] = (m_cnt[ch] >> 16) & 16'hFFFF;
    m_lo[ch] = m_cnt[ch] & 16'hFFFF;
    m_high[ch] = m_hi[ch] > 0;
    m_left[ch] = m_high[ch] ? m_hi[ch] : m_lo[ch];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0;
      for (int c = 0; c < 2; c++) begin
        m_cnt[c] = 0; m_pc[c] = 0; m_left[c] = 0; m_hi[c] = 0; m_lo[c] = 0; m_high[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        bit st, adv, tk;
        st = bus_wr && bus_addr == 4'd8 && bus_wdata[c] && !f_en(c);
        if (st) begin
          m_pc[c] = 0;
          load(c);
        end else begin
          adv = f_ce(c) && src_tick[f_sel(c)];
          tk = adv && (m_pc[c] == f_div(c));
          if (adv) m_pc[c] = tk ? 0 : m_pc[c] + 1;
          if (f_en(c) && tk) begin
            if (m_left[c] <= 1) begin
              if (m_high[c] && m_lo[c] > 0) begin
                m_high[c] = 0; m_left[c] = m_lo[c];
              end else load(c);
            end else m_left[c] = m_left[c] - 1;
          end
        end
      end
      if (bus_wr) begin
        if (bus_addr == 4'd0) m_cnt[0] = bus_wdata;
        if (bus_addr == 4'd4) m_cnt[1] = bus_wdata;
        if (bus_addr == 4'd8) m_ctrl = bus_wdata & 32'h00FF_FFF3;
      end
    end
  end

  function automatic logic [1:0] m_out();
    return {f_en(1) && m_high[1], f_en(0) && m_high[0]};
  endfunction

  // per-cycle comparison covers R3 R5 R7 R8 R9 R10
  always @(negedge clk) begin
    if (model_on && !done) begin
      n_chk++;
      if (pwm_out !== m_out()) begin
        n_fail++;
        $display("FAIL R5/R8/R10 cycle %0d: pwm_out=%b expected=%b", cyc, pwm_out, m_out());
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
  endtask

  task automatic rd(string req, logic [3:0] a, logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1 chk(req, bus_rdata, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] cw(bit ea, bit eb, int sa, int sb, int da, int db, bit ca, bit cb);
    return 32'(ea) | (32'(eb) << 1) | (32'(sa & 3) << 4) | (32'(sb & 3) << 6) |
           (32'(da & 127) << 8) | (32'(ca) << 15) | (32'(db & 127) << 16) | (32'(cb) << 23);
  endfunction

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 out", {30'd0, pwm_out}, 32'd0);
    rst_n = 1'b1;
    rd("R1 countA", 4'd0, 32'd0);
    rd("R1 countB", 4'd4, 32'd0);
    rd("R1 ctrl",   4'd8, 32'd0);
    model_on = 1;

    // R5: A high 3 / low 2, source 0, divide 1
    wr(4'd0, {16'd3, 16'd2});
    wr(4'd8, cw(1, 0, 0, 0, 0, 0, 1, 0));
    chk("R9 restart high", {31'd0, pwm_out[0]}, 32'd1);
    idle(40);

    // R3 R10: B high 2 / low 5, source 2, prescaler 1
    wr(4'd4, {16'd2, 16'd5});
    wr(4'd8, cw(1, 1, 0, 2, 0, 1, 1, 1));
    idle(80);
    rd("R2 countB", 4'd4, {16'd2, 16'd5});

    // R2: unmapped address ignored
    wr(4'd12, 32'hDEAD_BEEF);
    rd("R2 unmapped", 4'd12, 32'd0);
    rd("R2 countA kept", 4'd0, {16'd3, 16'd2});

    // R8: sweep count writes over every offset of the period
    for (int k = 0; k < 8; k++) begin
      idle(k);
      wr(4'd0, {16'(1 + k % 3), 16'(1 + k % 2)});
      idle(12);
    end

    // R3: random source 3 with prescaler 2 on A
    wr(4'd8, cw(1, 1, 3, 2, 2, 1, 1, 1));
    idle(120);

    // R4: gate A off, output frozen
    begin
      logic held;
      wr(4'd8, cw(1, 1, 3, 2, 2, 1, 0, 1));
      held = pwm_out[0];
      for (int i = 0; i < 20; i++) begin
        @(negedge clk); #1;
        chk("R4 hold", {31'd0, pwm_out[0]}, {31'd0, held});
      end
    end

    // R6: disable A cuts at once
    wr(4'd8, cw(1, 1, 0, 2, 0, 1, 1, 1));
    wr(4'd0, {16'd20, 16'd2});
    wr(4'd8, cw(0, 1, 0, 2, 0, 1, 1, 1));
    wr(4'd8, cw(1, 1, 0, 2, 0, 1, 1, 1));
    idle(3);
    chk("R9 mid high", {31'd0, pwm_out[0]}, 32'd1);
    wr(4'd8, cw(0, 1, 0, 2, 0, 1, 1, 1));
    chk("R6 cut", {31'd0, pwm_out[0]}, 32'd0);

    // R7: high 0 stays low
    wr(4'd0, {16'd0, 16'd3});
    wr(4'd8, cw(1, 1, 0, 2, 0, 1, 1, 1));
    for (int i = 0; i < 15; i++) begin
      @(negedge clk); #1;
      chk("R7 low", {31'd0, pwm_out[0]}, 32'd0);
    end
    // R7: low 0 stays high after boundary
    wr(4'd0, {16'd2, 16'd0});
    idle(8);
    for (int i = 0; i < 15; i++) begin
      @(negedge clk); #1;
      chk("R7 high", {31'd0, pwm_out[0]}, 32'd1);
    end
    // R7: both zero low
    wr(4'd0, 32'd0);
    idle(8);
    chk("R7 both zero", {31'd0, pwm_out[0]}, 32'd0);

    // R2: control readback masked
    wr(4'd8, 32'hFFFF_FFFF);
    rd("R2 ctrl mask", 4'd8, 32'h00FF_FFF3);
    idle(30);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule